// File: doc/BRIEF.md
# Triggered Circular Wavetable Player

The block plays one stored period of a waveform into a converter holding register, one sample per timebase trigger. No processor is involved once it is set up. Two fixed tables are built in. The main one holds a sine sampled every 6 degrees. The short one holds the same sine sampled every 45 degrees.

A static configuration picks the table and the number of entries to play. Separate inputs enable the channel and enable triggering. Each accepted trigger does one transfer. The transfer reads the word at the current read address and writes it into the fixed output register. The address then steps forward, and a remaining-transfer counter steps down.

When the counter runs out, the address returns to the first entry and the counter reloads from the configured length. Playback therefore repeats forever. The output frequency is the trigger rate divided by the length. For example, a 60 kHz trigger gives 1 kHz with 60 entries and 7.5 kHz with 8 entries.

Top module: `wave_player`

## Requirements
- R1: During and after reset, `dacHold` is 0x800 and `overrunCount` is 0.
- R2: With `tableSel`=0, entry k holds round(2048 + 2040·sin(6k°)) for k = 0..59. Entry 0 is 0x800, entry 15 is 0xFF8 and entry 45 is 0x008. `dacHold` never leaves the range 8..4088.
- R3: `dacHold` keeps its value in every cycle in which no transfer completes.
- R4: A trigger is accepted on a rising edge where `trigIn`, `chanEnable` and `trigEnable` are all 1 and no transfer is pending. The new sample is visible on `dacHold` after the following rising edge, which is two edges after the trigger is sampled.
- R5: Successive transfers read consecutive entries starting at entry 0. After entry L-1 (L = `cfgLength`) the next transfer reads entry 0 again. A length of 0 behaves as a length of 1.
- R6: While `chanEnable` is 0, triggers cause no transfer and `dacHold` holds. The read address returns to entry 0 and the counter reloads, so after re-enabling the first trigger plays entry 0.
- R7: While `trigEnable` is 0, `trigIn` has no effect on `dacHold`.
- R8: A trigger sampled while a transfer is pending does not cause an extra transfer. Instead it increments `overrunCount`, which saturates at all ones and is cleared to 0 while `chanEnable` is 0.
- R9: With `tableSel`=1, entry k is the value at index k mod 8 of the list 0x800, 0xDA2, 0xFF8, 0xDA2, 0x800, 0x25E, 0x008, 0x25E.
- R10: A change of `cfgLength` during playback takes effect only at the next wrap or the next re-enable. Entries already counted play out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEnable | input | 1 | Channel enable; low holds the output and rewinds playback |
| trigEnable | input | 1 | Trigger acceptance enable |
| tableSel | input | 1 | 0 selects the 60-entry table, 1 the 8-entry table |
| cfgLength | input | LEN_W (6) | Number of entries per playback period |
| trigIn | input | 1 | Timebase trigger, one pulse per sample |
| dacHold | output | SAMPLE_W (12) | Converter holding register |
| overrunCount | output | OVR_W (8) | Saturating count of triggers that arrived while a transfer was pending |

## Verification
A wrong read address shows up on `dacHold` as a sample out of sequence. This appears two edges after the trigger that reads it. A wrong remaining-count or reload instead stays hidden until the wrap, where entry 0 fails to follow entry L-1. For that reason every vector plays beyond one full period. Pending-state faults show up as a doubled step in the sequence, or as a wrong `overrunCount`, after a single two-cycle trigger.

// File: rtl/wave_pkg.sv
package wave_pkg;
  typedef struct packed {
    logic reload;
    logic xfer;
  } ctrlStrobe_t;
endpackage

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wave_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEnable,
  input  logic             trigEnable,
  input  logic             trigIn,
  output ctrlStrobe_t      strobe,
  output logic [OVR_W-1:0] overrunCount
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic pending;
  logic accept;

  assign accept = chanEnable & trigEnable & trigIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending      <= 1'b0;
      overrunCount <= '0;
    end else if (!chanEnable) begin
      pending      <= 1'b0;
      overrunCount <= '0;
    end else if (pending) begin
      pending <= 1'b0;
      if (accept && overrunCount != OVR_MAX) overrunCount <= overrunCount + 1'b1;
    end else begin
      pending <= accept;
    end
  end

  always_comb begin
    strobe.reload = ~chanEnable;
    strobe.xfer   = pending;
  end
endmodule

// File: rtl/wave_datapath.sv
module wave_datapath
  import wave_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                tableSel,
  input  logic [LEN_W-1:0]    cfgLength,
  output logic [SAMPLE_W-1:0] dacHold
);
  localparam int FULL      = 1 << SAMPLE_W;
  localparam int MID       = 1 << (SAMPLE_W - 1);
  localparam int MAIN_SIZE = 60;
  localparam int QUARTER   = MAIN_SIZE / 4;

  logic [LEN_W-1:0]    addr;
  logic [LEN_W-1:0]    remain;
  logic [LEN_W-1:0]    lenEff;
  logic [SAMPLE_W-1:0] word;

  function automatic int quarterSine(input int i);
    case (i)
      0: return 2048;   1: return 2261;   2: return 2472;   3: return 2678;
      4: return 2878;   5: return 3068;   6: return 3247;   7: return 3413;
      8: return 3564;   9: return 3698;  10: return 3815;  11: return 3912;
      12: return 3988; 13: return 4043;  14: return 4077;  15: return 4088;
      default: return MID;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] mainWord(input int idx);
    int v;
    if (idx <= QUARTER)                      v = quarterSine(idx);
    else if (idx <= 2*QUARTER)               v = quarterSine(2*QUARTER - idx);
    else if (idx <= 3*QUARTER)               v = FULL - quarterSine(idx - 2*QUARTER);
    else if (idx < MAIN_SIZE)                v = FULL - quarterSine(MAIN_SIZE - idx);
    else                                     v = MID;
    return SAMPLE_W'(v);
  endfunction

  function automatic logic [SAMPLE_W-1:0] shortWord(input logic [2:0] idx);
    int v;
    case (idx)
      3'd0, 3'd4: v = MID;
      3'd1, 3'd3: v = 3490;
      3'd2:       v = 4088;
      3'd5, 3'd7: v = FULL - 3490;
      default:    v = FULL - 4088;
    endcase
    return SAMPLE_W'(v);
  endfunction

  assign lenEff = (cfgLength == '0) ? LEN_W'(1) : cfgLength;
  assign word   = tableSel ? shortWord(addr[2:0]) : mainWord(int'(addr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      remain  <= lenEff;
      dacHold <= SAMPLE_W'(MID);
    end else if (strobe.reload) begin
      addr   <= '0;
      remain <= lenEff;
    end else if (strobe.xfer) begin
      dacHold <= word;
      if (remain <= LEN_W'(1)) begin
        addr   <= '0;
        remain <= lenEff;
      end else begin
        addr   <= addr + 1'b1;
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wave_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LEN_W    = 6,
  parameter int OVR_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanEnable,
  input  logic                trigEnable,
  input  logic                tableSel,
  input  logic [LEN_W-1:0]    cfgLength,
  input  logic                trigIn,
  output logic [SAMPLE_W-1:0] dacHold,
  output logic [OVR_W-1:0]    overrunCount
);
  ctrlStrobe_t strobes;

  wave_ctrl #(.OVR_W(OVR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .trigEnable(trigEnable),
    .trigIn(trigIn), .strobe(strobes), .overrunCount(overrunCount)
  );

  wave_datapath #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobes), .tableSel(tableSel),
    .cfgLength(cfgLength), .dacHold(dacHold)
  );
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
  parameter int SAMPLE_W = 12,
  parameter int OVR_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                chanEnable,
  input logic                trigEnable,
  input logic                trigIn,
  input logic                xfer,
  input logic [SAMPLE_W-1:0] dacHold,
  input logic [OVR_W-1:0]    overrunCount
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !xfer |=> $stable(dacHold)); // R3

  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (dacHold >= SAMPLE_W'(8)) && (dacHold <= SAMPLE_W'(4088))); // R2

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> $stable(dacHold)); // R6

  AST_TRIG_STARTS_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && trigEnable && trigIn && !xfer) |=> xfer); // R4

  AST_NO_TRIG_NO_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (!trigEnable && !xfer) |=> !xfer); // R7

  AST_OVR_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    chanEnable |=> (overrunCount >= $past(overrunCount))); // R8

  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> (overrunCount == '0)); // R8
endmodule

bind wave_player wave_player_chk #(.SAMPLE_W(SAMPLE_W), .OVR_W(OVR_W)) i_chk (
  .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .trigEnable(trigEnable),
  .trigIn(trigIn), .xfer(strobes.xfer), .dacHold(dacHold), .overrunCount(overrunCount)
);

// File: tb/test_wave_player.sv
`timescale 1ns/1ps
module test_wave_player;
  logic       clk = 1'b0;
  logic       rstN;
  logic       chanEnable, trigEnable, tableSel, trigIn;
  logic [5:0] cfgLength;
  logic [11:0] dacHold;
  logic [7:0]  overrunCount;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wave_player i_wave_player (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .trigEnable(trigEnable),
    .tableSel(tableSel), .cfgLength(cfgLength), .trigIn(trigIn),
    .dacHold(dacHold), .overrunCount(overrunCount)
  );

  typedef struct packed {
    logic        sel;
    logic [5:0]  len;
    logic [7:0]  steps;
    logic [11:0] last;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 6'd60, 8'd62, 12'h8D5},
    '{1'b1, 6'd8,  8'd10, 12'hDA2},
    '{1'b0, 6'd5,  8'd7,  12'h8D5},
    '{1'b1, 6'd3,  8'd4,  12'h800}
  };

  function automatic int expWord(input bit sel, input int idx);
    real deg;
    deg = sel ? 45.0 * (idx % 8) : 6.0 * idx;
    return int'(2048.0 + 2040.0 * $sin(deg * 3.14159265358979 / 180.0));
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
    end
  endtask

  task automatic pulse(input int width);
    @(negedge clk) trigIn = 1'b1;
    repeat (width) @(posedge clk);
    @(negedge clk) trigIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input bit sel, input logic [5:0] len);
    @(negedge clk) chanEnable = 1'b0; tableSel = sel; cfgLength = len;
    @(negedge clk) chanEnable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int prev;
    rstN = 1'b0; chanEnable = 1'b0; trigEnable = 1'b0; tableSel = 1'b0;
    trigIn = 1'b0; cfgLength = 6'd60;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 hold in reset", dacHold, 12'h800);
    check("R1 overrun in reset", overrunCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 hold after reset", dacHold, 12'h800);
    trigEnable = 1'b1;

    // Vector walk: R2 R4 R5 R9
    for (int v = 0; v < 4; v++) begin
      restart(VECS[v].sel, VECS[v].len);
      for (int s = 0; s < int'(VECS[v].steps); s++) begin
        pulse(1);
        check(VECS[v].sel ? "R9 short entry" : "R2 R5 main entry", dacHold,
              expWord(VECS[v].sel, s % int'(VECS[v].len)));
      end
      check("R5 wrap final", dacHold, VECS[v].last);
    end

    // R2 landmarks and R3 hold
    restart(1'b0, 6'd60);
    for (int s = 0; s < 46; s++) begin
      pulse(1);
      if (s == 15) check("R2 peak", dacHold, 12'hFF8);
    end
    check("R2 trough", dacHold, 12'h008);
    repeat (5) @(negedge clk);
    check("R3 hold idle", dacHold, 12'h008);

    // R4 timing: not visible after first edge
    restart(1'b0, 6'd60);
    @(negedge clk) trigIn = 1'b1;
    @(posedge clk);
    @(negedge clk) trigIn = 1'b0;
    check("R4 not yet after one edge", dacHold, 12'h008);
    @(negedge clk);
    check("R4 visible after second edge", dacHold, 12'h800);

    // R7 trigger enable
    pulse(1);
    @(negedge clk) trigEnable = 1'b0;
    pulse(1);
    check("R7 trigger ignored", dacHold, 12'h8D5);
    @(negedge clk) trigEnable = 1'b1;

    // R6 disable rewinds
    pulse(1);
    check("R6 entry2 before disable", dacHold, 12'h9A8);
    @(negedge clk) chanEnable = 1'b0;
    pulse(1);
    check("R6 no transfer while off", dacHold, 12'h9A8);
    @(negedge clk) chanEnable = 1'b1;
    pulse(1);
    check("R6 restart at entry0", dacHold, 12'h800);
    pulse(1);
    check("R6 then entry1", dacHold, 12'h8D5);

    // R8 overrun: two-cycle trigger gives one transfer
    restart(1'b0, 6'd60);
    pulse(1);
    pulse(2);
    check("R8 single extra transfer", dacHold, 12'h8D5);
    check("R8 overrun counted", overrunCount, 1);
    pulse(1);
    check("R8 sequence continues", dacHold, 12'h9A8);
    pulse(600);
    check("R8 overrun saturates", overrunCount, 255);
    @(negedge clk) chanEnable = 1'b0;
    @(negedge clk);
    check("R8 overrun cleared", overrunCount, 0);

    // R5 length 0 acts as 1
    restart(1'b0, 6'd60);
    pulse(1); pulse(1);
    prev = dacHold;
    check("R5 setup entry1", prev, 12'h8D5);
    restart(1'b0, 6'd0);
    for (int s = 0; s < 3; s++) begin
      pulse(1);
      check("R5 length zero repeats entry0", dacHold, 12'h800);
    end

    // R10 length change takes effect at wrap
    restart(1'b0, 6'd4);
    pulse(1); pulse(1);
    @(negedge clk) cfgLength = 6'd2;
    pulse(1);
    check("R10 entry2 after change", dacHold, expWord(0, 2));
    pulse(1);
    check("R10 entry3 after change", dacHold, expWord(0, 3));
    pulse(1);
    check("R10 wrap to entry0", dacHold, expWord(0, 0));
    pulse(1);
    check("R10 new length entry1", dacHold, expWord(0, 1));
    pulse(1);
    check("R10 new length wraps", dacHold, expWord(0, 0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule